// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects eleven interrupt sources for a signal-processing core, picks the most urgent one that may be serviced, and gives the sequencer a request flag and a fixed vector address. Source positions are ranked by urgency: index 0 is the nonmaskable power-down request and index 10 is the timer. The block's own reset stands for the reset source. While reset is held, the vector output is 0x0000.

Sources are either captured by a rising-edge latch or followed as levels. Two external pins are always level. Three external pins can be switched between edge and level. The rest, including the dedicated edge pin and all internal peripheral sources, are always edge. Software controls the block through a mask write, a sense/nesting control write, a force/clear strobe, and global enable and disable pulses. The sequencer answers a request with `ack` and signals the end of a handler with `rti`.

In nested mode, a source of higher urgency than every handler in progress can preempt. In sequential mode, any handler in progress holds off all new service until its return.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Index k ranks above index j when k < j. When several sources are eligible, `irq_vec` gives the vector of the lowest eligible index. The vector of index 0 is 0x002C. The vector of index k for k = 1..10 is 4*k: irq2=1 (0x04), lvl-a=2, lvl-b=3, tx0=4, rx0=5, edge pin=6 (0x18), dma=7, irq1=8, irq0=9, timer=10 (0x28).
- R2: A source with k >= 1 is eligible only when `msk_wdata` bit k was last written as 1. Bit 0 has no effect, so index 0 is never masked. After reset, all mask bits are 0.
- R3: In the cycle after a cycle with `msk_we` high, `irq_req` is 0.
- R4: Indices 2 and 3 are always level-sensitive. The configurable indices are irq2=1 (`ctl_edge[0]`), irq1=8 (`ctl_edge[1]`) and irq0=9 (`ctl_edge[2]`): 1 means edge and 0 means level, and reset selects level. All other indices are always edge-sensitive. A level source is pending only while its input is high.
- R5: An edge source becomes pending on a rising edge of its input. It stays pending after the input falls, until it is cleared.
- R6: `fc_set` bit k makes an edge-mode source pending, and `fc_clr` bit k clears it. Both have no effect on a source in level mode.
- R7: A `glb_dis` pulse stops all requests, including index 0, from the next cycle on. A `glb_en` pulse restores them. Reset leaves requests enabled. If both pulses arrive in the same cycle, disable wins.
- R8: `ack` while `irq_req` is high clears the edge latch of the presented source and marks it in service. `ack` while `irq_req` is low has no effect.
- R9: In nested mode (`ctl_nest`=1), sources at or below the urgency of the most urgent handler in service are held off. Sources above it still request. `rti` ends the most urgent handler.
- R10: In sequential mode (`ctl_nest`=0, the reset value), no request is raised while any handler is in service.
- R11: During and right after reset, `irq_req` is 0 and `irq_vec` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 11 | Raw source lines, index = urgency rank |
| msk_we | input | 1 | Mask write strobe |
| msk_wdata | input | 11 | Mask value, 1 = enabled |
| ctl_we | input | 1 | Sense/nesting control write strobe |
| ctl_edge | input | 3 | Edge select for irq2, irq1, irq0 |
| ctl_nest | input | 1 | 1 = nested, 0 = sequential |
| fc_set | input | 11 | Force edge latches (strobe) |
| fc_clr | input | 11 | Clear edge latches (strobe) |
| glb_en | input | 1 | Global enable pulse |
| glb_dis | input | 1 | Global disable pulse |
| ack | input | 1 | Sequencer accepts the presented vector |
| rti | input | 1 | Return from the most urgent handler |
| irq_req | output | 1 | Request to the sequencer |
| irq_vec | output | 14 | Vector address of the selected source |

## Verification
The bench drives every pair of sources at once and checks that the lower index wins. If the priority order were reversed or the power-down vector were numbered like the others, wrong addresses would come out. It writes the mask while a level request is active and looks for the single quiet cycle; a design with no blanking would keep requesting. It forces a level source and drops an edge input to show that one stays quiet and the other stays latched. It then walks through nested preemption, blocking of a same-priority source, and sequential hold-off across `rti`. A design that mixed up these orderings would either preempt when it should not, or lose the lower request after the return.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC  = 11;
  localparam int IDXW  = $clog2(NSRC);
  localparam int VEC_W = 14;
  localparam int STEP  = 4;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDXW-1:0] idx);
    if (idx == '0) vec_of = VEC_W'(NSRC * STEP);
    else           vec_of = VEC_W'(idx) * VEC_W'(STEP);
  endfunction
endpackage

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] frc,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar k = 0; k < N; k++) begin : g_src
    logic prev_q, lat_q, lat_d;

    always_comb begin
      if (edge_mode[k]) lat_d = (lat_q & ~clr[k]) | (src[k] & ~prev_q) | frc[k];
      else              lat_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= src[k];
        lat_q  <= lat_d;
      end
    end

    assign pend[k] = edge_mode[k] ? lat_q : src[k];

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[k] && lat_q && !clr[k]) |=> (lat_q || !edge_mode[k])); // R5
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N    = 11,
  parameter int IDXW = 4
) (
  input  logic [N-1:0]    elig,
  output logic            any,
  output logic [IDXW-1:0] sel
);
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) sel = IDXW'(i);
    end
    any = |elig;
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
  parameter int N    = 11,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nest,
  input  logic            push,
  input  logic [IDXW-1:0] push_idx,
  input  logic            pop,
  output logic [N-1:0]    isr,
  output logic [N-1:0]    block
);
  logic [N-1:0]    isr_q, isr_d;
  logic [IDXW-1:0] top_idx;
  logic            busy;

  always_comb begin
    top_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (isr_q[i]) top_idx = IDXW'(i);
    end
    busy = |isr_q;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (nest) block[i] = busy && (IDXW'(i) >= top_idx);
      else      block[i] = busy;
    end
  end

  always_comb begin
    isr_d = isr_q;
    if (pop && busy) isr_d[top_idx] = 1'b0;
    if (push)        isr_d[push_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          isr_q <= '0;
    else if (push || pop) isr_q <= isr_d;
  end

  assign isr = isr_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int IDX_IRQ2 = 1,
  parameter int IDX_IRQ1 = 8,
  parameter int IDX_IRQ0 = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             msk_we,
  input  logic [NSRC-1:0]  msk_wdata,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_edge,
  input  logic             ctl_nest,
  input  logic [NSRC-1:0]  fc_set,
  input  logic [NSRC-1:0]  fc_clr,
  input  logic             glb_en,
  input  logic             glb_dis,
  input  logic             ack,
  input  logic             rti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  localparam logic [NSRC-1:0] FIX_EDGE  = ~(NSRC'(1) << 2 | NSRC'(1) << 3);
  localparam logic [NSRC-1:0] NMI_BITS  = NSRC'(1);

  logic [NSRC-1:0] mask_q, mask_d;
  logic            blank_q;
  logic            gen_q, gen_d;
  logic            nest_q;
  logic [2:0]      ecfg_q;

  logic [NSRC-1:0] edge_mode, pend, elig, clr_v, isr, block, isr_upto;
  logic            any;
  logic [IDXW-1:0] sel;
  logic            ack_ok;

  always_comb begin
    edge_mode           = FIX_EDGE;
    edge_mode[IDX_IRQ2] = ecfg_q[0];
    edge_mode[IDX_IRQ1] = ecfg_q[1];
    edge_mode[IDX_IRQ0] = ecfg_q[2];
  end

  always_comb begin
    mask_d = msk_wdata;
    if (glb_dis)     gen_d = 1'b0;
    else if (glb_en) gen_d = 1'b1;
    else             gen_d = gen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      blank_q <= 1'b0;
      gen_q   <= 1'b1;
      nest_q  <= 1'b0;
      ecfg_q  <= '0;
    end else begin
      blank_q <= msk_we;
      gen_q   <= gen_d;
      if (msk_we) mask_q <= mask_d;
      if (ctl_we) begin
        nest_q <= ctl_nest;
        ecfg_q <= ctl_edge;
      end
    end
  end

  assign ack_ok = ack && irq_req;
  assign clr_v  = fc_clr | (ack_ok ? (NSRC'(1) << sel) : '0);

  irq_edge_bank #(.N(NSRC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src_i),
    .edge_mode (edge_mode),
    .frc       (fc_set),
    .clr       (clr_v),
    .pend      (pend)
  );

  irq_svc_track #(.N(NSRC), .IDXW(IDXW)) u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .nest     (nest_q),
    .push     (ack_ok),
    .push_idx (sel),
    .pop      (rti),
    .isr      (isr),
    .block    (block)
  );

  assign elig = pend & (mask_q | NMI_BITS) & ~block;

  irq_prio_sel #(.N(NSRC), .IDXW(IDXW)) u_sel (
    .elig (elig),
    .any  (any),
    .sel  (sel)
  );

  assign irq_req = any && gen_q && !blank_q;
  assign irq_vec = irq_req ? vec_of(sel) : '0;

  assign isr_upto = isr & ((NSRC'(1) << (32'(sel) + 1)) - NSRC'(1));

  AST_MASK_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msk_we) |-> !irq_req); // R3
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(glb_dis) |-> !irq_req); // R7
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !nest_q) |-> (isr == '0)); // R10
  AST_NEST_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && nest_q) |-> (isr_upto == '0)); // R9
  AST_PD_NOMASK: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && gen_q && !blank_q && isr == '0) |-> (irq_req && irq_vec == VEC_W'(NSRC * STEP))); // R2
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int N = 11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] src_i, msk_wdata, fc_set, fc_clr;
  logic        msk_we, ctl_we, ctl_nest, glb_en, glb_dis, ack, rti;
  logic [2:0]  ctl_edge;
  logic        irq_req;
  logic [13:0] irq_vec;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .msk_we(msk_we), .msk_wdata(msk_wdata),
    .ctl_we(ctl_we), .ctl_edge(ctl_edge), .ctl_nest(ctl_nest), .fc_set(fc_set),
    .fc_clr(fc_clr), .glb_en(glb_en), .glb_dis(glb_dis), .ack(ack), .rti(rti),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic logic [13:0] ev(input int k);
    return (k == 0) ? 14'd44 : 14'(4 * k);
  endfunction

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic er, input logic [13:0] evv);
    total++;
    if (irq_req !== er || irq_vec !== evv) begin
      bad++;
      $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h", tag, irq_req, irq_vec, er, evv);
    end
  endtask

  task automatic wr_mask(input logic [N-1:0] m);
    msk_we = 1'b1; msk_wdata = m; cyc(); msk_we = 1'b0; cyc();
  endtask

  task automatic wr_ctl(input logic [2:0] e, input logic n);
    ctl_we = 1'b1; ctl_edge = e; ctl_nest = n; cyc(); ctl_we = 1'b0;
  endtask

  task automatic force_src(input int k);
    fc_set = N'(1) << k; cyc(); fc_set = '0;
  endtask

  task automatic clear_all();
    src_i = '0; fc_clr = '1; cyc(); fc_clr = '0; cyc();
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic pulse_rti();
    rti = 1'b1; cyc(); rti = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_i = '0; msk_we = 1'b0; msk_wdata = '0; ctl_we = 1'b0;
    ctl_edge = '0; ctl_nest = 1'b0; fc_set = '0; fc_clr = '0; glb_en = 1'b0;
    glb_dis = 1'b0; ack = 1'b0; rti = 1'b0;
    cyc(); cyc();
    chk("R11 in reset", 1'b0, 14'h0);
    rst_n = 1'b1; cyc();
    chk("R11 after reset", 1'b0, 14'h0);

    // R2: reset mask blocks maskable; index 0 ignores mask
    src_i[2] = 1'b1; cyc();
    chk("R2 masked level", 1'b0, 14'h0);
    src_i = '0;
    force_src(0);
    chk("R2 nonmaskable", 1'b1, ev(0));
    clear_all();
    wr_mask(11'h001);
    src_i[3] = 1'b1; cyc();
    chk("R2 bit0 only", 1'b0, 14'h0);
    clear_all();

    // R1: all pairs, all edge where selectable
    wr_mask('1);
    wr_ctl(3'b111, 1'b0);
    for (int a = 0; a < N; a++) begin
      for (int b = a; b < N; b++) begin
        src_i = (N'(1) << a) | (N'(1) << b);
        cyc();
        chk("R1 pair", 1'b1, ev(a));
        clear_all();
        chk("R1 cleared", 1'b0, 14'h0);
      end
    end

    // R3: blanking after mask write
    src_i[2] = 1'b1; cyc();
    chk("R3 before", 1'b1, ev(2));
    msk_we = 1'b1; msk_wdata = '1; cyc(); msk_we = 1'b0;
    chk("R3 blank", 1'b0, 14'h0);
    cyc();
    chk("R3 after", 1'b1, ev(2));
    clear_all();

    // R4 / R5: configurable sense
    wr_ctl(3'b000, 1'b0);
    src_i[1] = 1'b1; cyc();
    chk("R4 level on", 1'b1, ev(1));
    src_i[1] = 1'b0; cyc();
    chk("R4 level off", 1'b0, 14'h0);
    wr_ctl(3'b001, 1'b0);
    src_i[1] = 1'b1; cyc(); src_i[1] = 1'b0; cyc();
    chk("R5 edge held", 1'b1, ev(1));
    clear_all();
    src_i[6] = 1'b1; cyc(); src_i[6] = 1'b0; cyc(); cyc();
    chk("R5 fixed edge held", 1'b1, ev(6));
    clear_all();

    // R6: force/clear
    force_src(2);
    chk("R6 force level ignored", 1'b0, 14'h0);
    force_src(6);
    chk("R6 force edge", 1'b1, ev(6));
    fc_clr = N'(1) << 6; cyc(); fc_clr = '0;
    chk("R6 clear edge", 1'b0, 14'h0);

    // R7: global disable
    glb_dis = 1'b1; cyc(); glb_dis = 1'b0;
    force_src(0);
    chk("R7 disabled", 1'b0, 14'h0);
    glb_en = 1'b1; cyc(); glb_en = 1'b0;
    chk("R7 enabled", 1'b1, ev(0));
    clear_all();

    // R8: acknowledge
    wr_ctl(3'b111, 1'b0);
    force_src(4);
    chk("R8 present", 1'b1, ev(4));
    pulse_ack();
    chk("R8 in service", 1'b0, 14'h0);
    pulse_rti();
    chk("R8 latch cleared", 1'b0, 14'h0);
    pulse_ack();
    force_src(6);
    chk("R8 idle ack ignored", 1'b1, ev(6));
    clear_all();

    // R10: sequential
    force_src(9);
    chk("R10 present", 1'b1, ev(9));
    pulse_ack();
    force_src(1);
    chk("R10 held off", 1'b0, 14'h0);
    pulse_rti();
    chk("R10 after return", 1'b1, ev(1));
    clear_all();

    // R9: nested
    wr_ctl(3'b111, 1'b1);
    force_src(5);
    chk("R9 present", 1'b1, ev(5));
    pulse_ack();
    force_src(7);
    chk("R9 lower blocked", 1'b0, 14'h0);
    src_i[3] = 1'b1; cyc();
    chk("R9 preempt", 1'b1, ev(3));
    pulse_ack();
    chk("R9 same blocked", 1'b0, 14'h0);
    pulse_rti();
    chk("R9 level back", 1'b1, ev(3));
    src_i[3] = 1'b0; cyc();
    chk("R9 still blocked", 1'b0, 14'h0);
    pulse_rti();
    chk("R9 lower resumes", 1'b1, ev(7));
    clear_all();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule